// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Hold Register

This block turns a 4-bit binary-coded decimal value into seven active-high segment drives for a common-cathode digit. A hold control lets the shown digit stay fixed while the code input keeps changing, for example while a counter runs on to its next value. Two active-low overrides sit at the output. One is a lamp test that lights every segment. The other is a blanking input that turns every segment off.

The hold behaves as a level-sensitive latch but is built as a clocked register. While hold is low, the register loads the code on every clock edge and the decoder reads the live code directly, so the display follows the input with no delay. While hold is high, the decoder reads the register, which keeps the code sampled at the last clock edge where hold was low. Codes 10 to 15 are not decimal digits and give a dark display. The lamp test takes priority over blanking, and both take priority over the decoded digit.

Top module: `seg_latch_decoder`

## Requirements
- R1: With lamp test and blank inactive (high) and hold low, codes 0 to 9 light these segments on `seg_o`, where bit 0 is segment a and bit 6 is segment g: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R2: Codes 10 to 15, whether live or held, drive `seg_o` to 0x00 when neither override is active.
- R3: While `hold_i` is low, `seg_o` follows `bcd_i` combinationally in the same cycle, and the hold register loads `bcd_i` at each rising clock edge.
- R4: While `hold_i` is high, `seg_o` shows the code that was present at the last rising edge where `hold_i` was low, and changes on `bcd_i` have no effect.
- R5: When `lamp_test_ni` is low, `seg_o` is 0x7F whatever the values of `blank_ni`, `hold_i` and `bcd_i`.
- R6: When `blank_ni` is low and `lamp_test_ni` is high, `seg_o` is 0x00 whatever the code.
- R7: Reset (`rst_ni` low) clears the hold register to code 0, so with `hold_i` high during and after reset the display shows 0x3F until a code is loaded.
- R8: The hold register keeps loading while an override is active. When the override is released with `hold_i` high, the display shows the code captured during the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bcd_i | input | 4 | BCD code to display |
| hold_i | input | 1 | High freezes the displayed code; low makes it transparent |
| lamp_test_ni | input | 1 | Active-low lamp test: all segments on |
| blank_ni | input | 1 | Active-low blanking: all segments off |
| seg_o | output | 7 | Segment drives, bit 0 = a through bit 6 = g, active high |

## Verification
The only internal state is the hold register. A wrong value there stays hidden while hold is low or an override is active. It appears on `seg_o` in the first cycle that hold is high with both overrides released, as a digit pattern other than the one captured. The bench builds those windows on purpose: it captures a code under blanking or lamp test and then releases the override with hold high. It also changes `bcd_i` through every code while hold is high, so that a register that still loads shows a changed pattern within one clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  parameter int unsigned CODE_W = 4;
  parameter int unsigned SEG_W  = 7;
  localparam int unsigned MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_W{1'b1}};
  localparam seg_t SEG_ALL_OFF = {SEG_W{1'b0}};

  typedef enum logic [1:0] {
    SRC_DIGIT = 2'd0,
    SRC_DARK  = 2'd1,
    SRC_LAMP  = 2'd2
  } out_src_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/seg_code_hold.sv
module seg_code_hold
  import seg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t code_i,
  input  logic  hold_i,
  output code_t shown_o
);
  code_t held_q;
  code_t held_d;
  logic  load_en;

  assign load_en = ~hold_i;

  always_comb begin
    held_d = held_q;
    if (load_en) held_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= held_d;
  end

  // transparent while hold is low, frozen otherwise
  assign shown_o = hold_i ? held_q : code_i;

  // R4: a held edge leaves the register untouched
  a_r4_hold_keeps_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(held_q));

  // R3: a transparent edge captures the live code
  a_r3_load_live_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (held_q == $past(code_i)));
endmodule

// File: rtl/seg_digit_decode.sv
module seg_digit_decode
  import seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  seg_o
);
  // bit order: {g,f,e,d,c,b,a}
  always_comb begin
    unique case (code_i)
      4'd0:    seg_o = 7'b011_1111;
      4'd1:    seg_o = 7'b000_0110;
      4'd2:    seg_o = 7'b101_1011;
      4'd3:    seg_o = 7'b100_1111;
      4'd4:    seg_o = 7'b110_0110;
      4'd5:    seg_o = 7'b110_1101;
      4'd6:    seg_o = 7'b111_1101;
      4'd7:    seg_o = 7'b000_0111;
      4'd8:    seg_o = 7'b111_1111;
      4'd9:    seg_o = 7'b110_1111;
      default: seg_o = SEG_ALL_OFF;
    endcase
  end
endmodule

// File: rtl/seg_override_mux.sv
module seg_override_mux
  import seg_pkg::*;
(
  input  seg_t digit_i,
  input  logic lamp_test_ni,
  input  logic blank_ni,
  output seg_t seg_o
);
  out_src_e src;

  always_comb begin
    if (!lamp_test_ni)  src = SRC_LAMP;
    else if (!blank_ni) src = SRC_DARK;
    else                src = SRC_DIGIT;
  end

  always_comb begin
    unique case (src)
      SRC_LAMP: seg_o = SEG_ALL_ON;
      SRC_DARK: seg_o = SEG_ALL_OFF;
      default:  seg_o = digit_i;
    endcase
  end
endmodule

// File: rtl/seg_latch_decoder.sv
module seg_latch_decoder
  import seg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] bcd_i,
  input  logic              hold_i,
  input  logic              lamp_test_ni,
  input  logic              blank_ni,
  output logic [SEG_W-1:0]  seg_o
);
  logic  rst_sync_n;
  code_t shown_code;
  seg_t  digit_seg;

  seg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  seg_code_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .code_i  (bcd_i),
    .hold_i  (hold_i),
    .shown_o (shown_code)
  );

  seg_digit_decode u_decode (
    .code_i (shown_code),
    .seg_o  (digit_seg)
  );

  seg_override_mux u_mux (
    .digit_i      (digit_seg),
    .lamp_test_ni (lamp_test_ni),
    .blank_ni     (blank_ni),
    .seg_o        (seg_o)
  );

  // R5: lamp test lights everything
  a_r5_lamp_all_on: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !lamp_test_ni |-> (seg_o == SEG_ALL_ON));

  // R6: blanking darkens everything unless lamp test wins
  a_r6_blank_dark: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lamp_test_ni && !blank_ni) |-> (seg_o == SEG_ALL_OFF));

  // R2: live non-decimal codes are dark
  a_r2_invalid_dark: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lamp_test_ni && blank_ni && !hold_i && (bcd_i > 4'(MAX_DIGIT)))
      |-> (seg_o == SEG_ALL_OFF));

  // R1: a live decimal digit lights at least two segments
  a_r1_digit_lit: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lamp_test_ni && blank_ni && !hold_i && (bcd_i <= 4'(MAX_DIGIT)))
      |-> ($countones(seg_o) >= 2));
endmodule

// File: tb/seg_latch_decoder_tb.sv
module seg_latch_decoder_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] bcd;
  logic       hold;
  logic       lamp_n;
  logic       blank_n;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;
  int held_m = 0;
  bit done   = 0;

  seg_latch_decoder u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bcd_i        (bcd),
    .hold_i       (hold),
    .lamp_test_ni (lamp_n),
    .blank_ni     (blank_n),
    .seg_o        (seg)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // reference model of the hold register
  always @(posedge clk) begin
    if (!rst_n)     held_m <= 0;
    else if (!hold) held_m <= int'(bcd);
  end

  function automatic logic [6:0] digit_pat(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg();
    int code;
    if (!lamp_n)  return 7'h7F;
    if (!blank_n) return 7'h00;
    code = hold ? held_m : int'(bcd);
    return digit_pat(code);
  endfunction

  task automatic check(input string req);
    logic [6:0] exp;
    exp = expect_seg();
    checks++;
    if (seg !== exp) begin
      errors++;
      $display("FAIL %s: bcd=%0d hold=%0b lt=%0b bl=%0b seg=%h expected=%h",
               req, bcd, hold, lamp_n, blank_n, seg, exp);
    end
  endtask

  // drive after a falling edge, check before the next rising edge
  task automatic step(input int code, input bit h, input bit lt, input bit bl,
                      input string req);
    @(negedge clk);
    bcd = 4'(code); hold = h; lamp_n = lt; blank_n = bl;
    #2;
    check(req);
  endtask

  initial begin
    rst_n = 0; bcd = 4'd7; hold = 1; lamp_n = 1; blank_n = 1;
    // R7: reset clears the held code to 0
    repeat (2) step(5, 1, 1, 1, "R7");
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) step(i + 11, 1, 1, 1, "R7");

    // R1 R2 R3: transparent sweep of all sixteen codes
    for (int c = 0; c < 16; c++) step(c, 0, 1, 1, (c > 9) ? "R2" : "R1_R3");
    for (int c = 15; c >= 0; c--) step(c, 0, 1, 1, "R3");

    // R5 R6: every override combination on every code, both hold states
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 8; m++)
        step(c, m[2], m[1], m[0], (!m[1]) ? "R5" : (!m[0]) ? "R6" : "R3_R4");

    // R4: freeze digit 6, then sweep the input
    step(6, 0, 1, 1, "R3");
    for (int c = 0; c < 16; c++) step(c, 1, 1, 1, "R4");
    // R2: frozen non-decimal code stays dark
    step(12, 0, 1, 1, "R2");
    for (int c = 0; c < 10; c++) step(c, 1, 1, 1, "R2_R4");
    // R4: freeze each digit in turn
    for (int c = 0; c < 10; c++) begin
      step(c, 0, 1, 1, "R3");
      step(9 - c, 1, 1, 1, "R4");
      step(15 - c, 1, 1, 1, "R4");
    end

    // R8: capture under blanking, release with hold high
    step(9, 0, 1, 0, "R6");
    step(3, 1, 1, 0, "R6");
    step(3, 1, 1, 1, "R8");
    // R8: capture under lamp test
    step(2, 0, 0, 1, "R5");
    step(8, 1, 0, 1, "R5");
    step(8, 1, 1, 1, "R8");
    step(4, 1, 1, 1, "R8");

    // counter driving the decoder, with periodic freezes
    for (int n = 0; n < 60; n++) step(n % 10, (n % 7) > 4, 1, 1, "R3_R4");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule